// File: doc/BRIEF.md
# Two-Level Radio Interrupt Aggregator

This block gathers single-bit status lines from the radio's sub-blocks and turns them into two interrupt requests for the CPU. One request carries normal-operation events. The other carries error events. Every status line has a sticky flag bit that records a 0-to-1 change, and a separate enable bit. The enable bit decides only whether the flag takes part in its group's combined request. The flag itself is always recorded.

There are sixteen normal sources, split over two register pairs, and eight error sources in a third pair. For each vector, the combined request feeds a second layer. That layer holds a CPU-level pending bit, set when the combined request rises, and a CPU-level enable bit. Software reaches every register through a small byte-wide bus: a 3-bit address, write data with a write strobe, and combinational read data. The CPU's vector logic can clear a pending bit with a one-cycle acknowledge pulse.

Because the pending bit responds only to a rising edge of the combined request, a source that becomes active while the request is already high does not produce a new CPU event. The interrupt handler must therefore scan all flags of a group before it leaves.

Top module: `radio_irq_agg`

## Requirements
- R1: Under reset (active-low, synchronous) every flag, mask, CPU-level enable and CPU-level pending bit is 0, every address reads 0, and both interrupt outputs are low.
- R2: A source flag is set at the first clock edge at which its input is 1 after having been 0 at the previous edge. An input that stays high does not set the flag again after software clears it.
- R3: A flag is set by its rising input even when that source's mask bit is 0.
- R4: Flag registers are at address 0 (normal group A, from `evt_nrm_a`), address 1 (normal group B, from `evt_nrm_b`) and address 2 (error group, from `evt_err`). Bit i of a register belongs to input bit i. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R5: When a rising input and a clearing write hit the same flag bit at the same edge, the flag ends up set.
- R6: Mask registers are at address 3 (group A), address 4 (group B) and address 5 (error group), and they are plain read/write. The normal combined request is the OR of flag AND mask over groups A and B. The error combined request uses the error group only.
- R7: The CPU-level pending bit of a vector is set at the edge where its combined request is 1 after being 0 at the previous edge. A further source becoming enabled and flagged while the request is already 1 does not set pending again.
- R8: A pending bit is cleared by an acknowledge pulse (`ack_nrm`, `ack_err`) or by writing 0 to it. A combined-request rising edge at the same edge as a clear wins, and pending stays set.
- R9: The control register at address 6 holds the normal enable in bit 0, the error enable in bit 1, the normal pending bit in bit 2 and the error pending bit in bit 3. The enable bits are written directly. Pending bits follow the write-0-clears rule. Each interrupt output is high exactly when that vector's pending bit and enable bit are both 1.
- R10: `reg_rdata` combinationally returns the register selected by `reg_addr`. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_nrm_a | input | 8 | Normal-event status lines, group A |
| evt_nrm_b | input | 8 | Normal-event status lines, group B |
| evt_err | input | 8 | Error status lines |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ack_nrm | input | 1 | Acknowledge pulse, normal vector |
| ack_err | input | 1 | Acknowledge pulse, error vector |
| irq_nrm | output | 1 | Normal-event interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
Sources are raised in three ways: while masked, while already enabled and requesting, and in the same cycle as a clearing write. These cases separate flag recording from request gating, and a true second-layer edge from a level-sensitive one. Clearing is exercised through both the acknowledge pulse and software writes, and also when it coincides with a fresh combined-request edge, which exposes the priority between set and clear. A normal group-B source is used after group A has gone quiet, to show that both normal groups merge into one vector. The error path is driven independently of the normal path, to catch any cross-coupling between the two vectors.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned N_GROUPS  = 3;   // two normal groups, one error group
    localparam int unsigned N_VECTORS = 2;   // 0: normal, 1: error

    localparam int unsigned ADR_FLAG_BASE = 0;
    localparam int unsigned ADR_MASK_BASE = 3;
    localparam int unsigned ADR_CTRL      = 6;

    localparam int unsigned CTRL_EN_BASE   = 0;
    localparam int unsigned CTRL_PEND_BASE = 2;

    function automatic int unsigned flag_addr(input int unsigned grp);
        return ADR_FLAG_BASE + grp;
    endfunction

    function automatic int unsigned mask_addr(input int unsigned grp);
        return ADR_MASK_BASE + grp;
    endfunction
endpackage

// File: rtl/radio_irq_group.sv
module radio_irq_group
    import radio_irq_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter int unsigned FLAG_ADDR = 0,
    parameter int unsigned MASK_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      flag_o,
    output logic [W-1:0]      mask_o,
    output logic              req_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] flag;
        logic [W-1:0] mask;
    } grp_state_t;

    grp_state_t   st_d, st_q;
    logic [W-1:0] rise;
    logic         hit_flag, hit_mask;

    always_comb begin
        st_d     = st_q;
        hit_flag = wr_en && (wr_addr == ADDR_W'(FLAG_ADDR));
        hit_mask = wr_en && (wr_addr == ADDR_W'(MASK_ADDR));
        rise     = evt & ~st_q.prev;
        st_d.prev = evt;
        if (hit_flag) begin
            st_d.flag = st_q.flag & wr_data;
        end
        st_d.flag = st_d.flag | rise;        // a fresh edge beats a clear
        if (hit_mask) begin
            st_d.mask = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign mask_o = st_q.mask;
    assign req_o  = |(st_q.flag & st_q.mask);

    AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((flag_o & $past(rise)) == $past(rise)));  // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_flag |=> ((flag_o & $past(flag_o)) == $past(flag_o)));  // R4
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_mask |=> (mask_o == $past(mask_o)));  // R6
endmodule

// File: rtl/radio_irq_cpu.sv
module radio_irq_cpu
    import radio_irq_pkg::*;
#(
    parameter int unsigned EN_BIT   = 0,
    parameter int unsigned PEND_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              ack,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic              en_o,
    output logic              pend_o,
    output logic              irq_o
);
    typedef struct packed {
        logic req_prev;
        logic en;
        logic pend;
    } cpu_state_t;

    cpu_state_t st_d, st_q;
    logic       req_edge;

    always_comb begin
        st_d          = st_q;
        req_edge      = req && !st_q.req_prev;
        st_d.req_prev = req;
        if (ctrl_we) begin
            st_d.en   = ctrl_wdata[EN_BIT];
            st_d.pend = st_q.pend & ctrl_wdata[PEND_BIT];
        end
        if (ack) begin
            st_d.pend = 1'b0;
        end
        if (req_edge) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.pend & st_q.en;

    AST_PEND_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_edge |=> pend_o);  // R7
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(req_edge));  // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req_edge) |=> !pend_o);  // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o && en_o));  // R9
endmodule

// File: rtl/radio_irq_agg.sv
module radio_irq_agg
    import radio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_nrm_a,
    input  logic [DATA_W-1:0] evt_nrm_b,
    input  logic [DATA_W-1:0] evt_err,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ack_nrm,
    input  logic              ack_err,
    output logic              irq_nrm,
    output logic              irq_err
);
    logic [DATA_W-1:0]    evt_grp  [N_GROUPS];
    logic [DATA_W-1:0]    flag_grp [N_GROUPS];
    logic [DATA_W-1:0]    mask_grp [N_GROUPS];
    logic [N_GROUPS-1:0]  req_grp;
    logic [N_VECTORS-1:0] req_vec, ack_vec, en_vec, pend_vec, irq_vec;
    logic                 ctrl_we;

    assign evt_grp[0] = evt_nrm_a;
    assign evt_grp[1] = evt_nrm_b;
    assign evt_grp[2] = evt_err;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        radio_irq_group #(
            .W         (DATA_W),
            .FLAG_ADDR (flag_addr(g)),
            .MASK_ADDR (mask_addr(g))
        ) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_grp[g]),
            .wr_en   (reg_we),
            .wr_addr (reg_addr),
            .wr_data (reg_wdata),
            .flag_o  (flag_grp[g]),
            .mask_o  (mask_grp[g]),
            .req_o   (req_grp[g])
        );
    end

    assign req_vec[0] = req_grp[0] | req_grp[1];
    assign req_vec[1] = req_grp[2];
    assign ack_vec    = {ack_err, ack_nrm};
    assign ctrl_we    = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));

    for (genvar v = 0; v < N_VECTORS; v++) begin : g_vec
        radio_irq_cpu #(
            .EN_BIT   (CTRL_EN_BASE + v),
            .PEND_BIT (CTRL_PEND_BASE + v)
        ) u_cpu (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req_vec[v]),
            .ack        (ack_vec[v]),
            .ctrl_we    (ctrl_we),
            .ctrl_wdata (reg_wdata),
            .en_o       (en_vec[v]),
            .pend_o     (pend_vec[v]),
            .irq_o      (irq_vec[v])
        );
    end

    assign irq_nrm = irq_vec[0];
    assign irq_err = irq_vec[1];

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (reg_addr == ADDR_W'(flag_addr(g))) reg_rdata = flag_grp[g];
            if (reg_addr == ADDR_W'(mask_addr(g))) reg_rdata = mask_grp[g];
        end
        if (reg_addr == ADDR_W'(ADR_CTRL)) begin
            reg_rdata[CTRL_EN_BASE   +: N_VECTORS] = en_vec;
            reg_rdata[CTRL_PEND_BASE +: N_VECTORS] = pend_vec;
        end
    end

    AST_NRM_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_nrm) |-> (pend_vec[0] && en_vec[0]));  // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_nrm && !irq_err));  // R1
endmodule

// File: tb/radio_irq_agg_tb.sv
module radio_irq_agg_tb;
    typedef struct packed {
        logic [7:0] a, b, e;
        logic       ackn, acke, we;
        logic [2:0] waddr;
        logic [7:0] wdata;
        logic [2:0] raddr;
        logic [7:0] rd;
        logic       in, ie;
    } vec_t;

    localparam int NV = 21;
    // Fields: a, b, e, ack_nrm, ack_err, we, waddr, wdata | raddr, rdata, irq_nrm, irq_err
    localparam vec_t TBL [NV] = '{
        '{8'h01,8'h00,8'h00,1'b0,1'b0,1'b1,3'd3,8'h01, 3'd0,8'h01,1'b0,1'b0}, // R2 R6 flag A0 set, mask A0
        '{8'h01,8'h00,8'h00,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd6,8'h04,1'b0,1'b0}, // R7 pending rises
        '{8'h01,8'h00,8'h00,1'b0,1'b0,1'b1,3'd6,8'h05, 3'd6,8'h05,1'b1,1'b0}, // R9 enable, pend write 1 keeps
        '{8'h03,8'h00,8'h00,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd0,8'h03,1'b1,1'b0}, // R3 masked source flagged
        '{8'h03,8'h00,8'h00,1'b0,1'b0,1'b1,3'd0,8'hFE, 3'd0,8'h02,1'b1,1'b0}, // R4 R2 clear bit0, level stays
        '{8'h03,8'h00,8'h00,1'b0,1'b0,1'b1,3'd6,8'h01, 3'd6,8'h01,1'b0,1'b0}, // R8 software clears pending
        '{8'h03,8'h80,8'h00,1'b0,1'b0,1'b1,3'd4,8'h80, 3'd1,8'h80,1'b0,1'b0}, // R6 group B
        '{8'h03,8'h80,8'h00,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd6,8'h05,1'b1,1'b0}, // R6 R7 group B drives normal vector
        '{8'h07,8'h80,8'h00,1'b0,1'b0,1'b1,3'd3,8'h07, 3'd0,8'h06,1'b1,1'b0}, // R7 second source while high
        '{8'h07,8'h80,8'h00,1'b1,1'b0,1'b0,3'd0,8'h00, 3'd6,8'h01,1'b0,1'b0}, // R8 ack clears
        '{8'h07,8'h80,8'h00,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd6,8'h01,1'b0,1'b0}, // R7 no re-trigger
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b1,3'd5,8'h10, 3'd2,8'h10,1'b0,1'b0}, // R6 error flag and mask
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b1,3'd6,8'h03, 3'd6,8'h0B,1'b0,1'b1}, // R9 error irq
        '{8'h07,8'h80,8'h00,1'b0,1'b1,1'b1,3'd2,8'h00, 3'd6,8'h03,1'b0,1'b0}, // R8 R4 error ack and clear
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b1,3'd2,8'h00, 3'd2,8'h10,1'b0,1'b0}, // R5 edge beats clear
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd6,8'h0B,1'b0,1'b1}, // R7 error pending again
        '{8'h07,8'h80,8'h00,1'b0,1'b1,1'b1,3'd2,8'h00, 3'd6,8'h03,1'b0,1'b0}, // R8 clear all
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd2,8'h10,1'b0,1'b0}, // R2 new edge
        '{8'h07,8'h80,8'h10,1'b0,1'b1,1'b0,3'd0,8'h00, 3'd6,8'h0B,1'b0,1'b1}, // R8 edge beats ack
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd7,8'h00,1'b0,1'b1}, // R10 unused address
        '{8'h07,8'h80,8'h10,1'b0,1'b0,1'b0,3'd0,8'h00, 3'd3,8'h07,1'b0,1'b1}  // R10 mask readback
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_nrm_a = '0, evt_nrm_b = '0, evt_err = '0;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_nrm = 1'b0, ack_err = 1'b0;
    logic       irq_nrm, irq_err;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    radio_irq_agg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_nrm_a (evt_nrm_a),
        .evt_nrm_b (evt_nrm_b),
        .evt_err   (evt_err),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack_nrm   (ack_nrm),
        .ack_err   (ack_err),
        .irq_nrm   (irq_nrm),
        .irq_err   (irq_err)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all_zero(input string req);
        for (int ad = 0; ad < 8; ad++) begin
            reg_addr = 3'(ad);
            #1;
            check(req, {irq_nrm, irq_err, reg_rdata}, 10'h000);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all_zero("R1 reset state");
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < NV; i++) begin
            evt_nrm_a = TBL[i].a;
            evt_nrm_b = TBL[i].b;
            evt_err   = TBL[i].e;
            ack_nrm   = TBL[i].ackn;
            ack_err   = TBL[i].acke;
            reg_we    = TBL[i].we;
            reg_addr  = TBL[i].waddr;
            reg_wdata = TBL[i].wdata;
            @(posedge clk);
            @(negedge clk);
            reg_we   = 1'b0;
            ack_nrm  = 1'b0;
            ack_err  = 1'b0;
            reg_addr = TBL[i].raddr;
            #1;
            check($sformatf("table row %0d", i), {irq_nrm, irq_err, reg_rdata},
                  {TBL[i].in, TBL[i].ie, TBL[i].rd});
        end
        // R1: reset in the middle of activity, with sources held high
        rst_n = 1'b0;
        evt_err = 8'hFF;
        evt_nrm_a = 8'hFF;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_all_zero("R1 mid-run reset");
        // R2 after reset: held-high inputs count as a fresh edge
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_addr = 3'd2;
        #1;
        check("R2 edge after reset", {irq_nrm, irq_err, reg_rdata}, {2'b00, 8'hFF});
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule